// File: doc/BRIEF.md
# Interrupt Completion Coalescing Controller

This block merges a stream of command-completion pulses into far fewer interrupts. Each completion pulse adds one to a completion counter. A timeout timer, advanced by an external 1 ms strobe, starts at the first completion after the last interrupt. A coalesced interrupt fires when the counter reaches a programmed threshold or when the timer reaches a programmed timeout, whichever comes first. When it fires, it sets one bit of a pending-status vector. A programmable index picks that bit.

Software sets the block up through one 32-bit control word. It holds the enable, the interrupt index, the completion threshold and the timeout. The threshold and the timeout are frozen while the block is enabled. A threshold of zero gives timer-only coalescing. A timeout of zero means the timer never fires. Software clears status bits by writing ones to the status word.

Top module: `cmpl_coalesce`

## Requirements
- R1: After reset the control word (bus_addr 0) reads 0x00010108. Its layout is timeout in bits 31:16, threshold in bits 15:8, index in bits 7:3, bits 2:1 and enable in bit 0. Bits 2:1 always read 0, whatever was written to them. The status word (bus_addr 1) reads 0.
- R2: A write to the control word while enable is 1 leaves the timeout and threshold unchanged. While enable is 0, a write loads them.
- R3: With a threshold N other than 0, the Nth completion pulse after enabling, or after the last interrupt, fires the interrupt. The status bit reads 1 from the cycle after that pulse. After N-1 pulses it is still 0.
- R4: With a timeout T other than 0, the interrupt fires on the edge where the Tth 1 ms tick is counted. Ticks are counted from the first completion after enabling or after the last interrupt.
- R5: A timeout of 0 never fires the interrupt, however many ticks arrive.
- R6: A firing sets status bit number index (0 to 31) and no other bit. A write to bus_addr 1 clears each status bit whose data bit is 1 and leaves the other status bits unchanged.
- R7: While enable is 0, completions and ticks set no status bit.
- R8: A firing clears both the completion count and the timer. Writing enable to 0 clears them too, so work counted before the block is disabled does not carry over.
- R9: Ticks that arrive while no completion is pending do not advance the timer.
- R10: A completion and a tick in the same cycle are both counted in that cycle.
- R11: When a set and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up 1.
- R12: With threshold 0, completions never fire on count alone. The interrupt comes only from the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmpl_pulse | input | 1 | One-cycle command completion event |
| ms_tick | input | 1 | One-cycle 1 ms timebase strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects the control word, 1 selects the status word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_addr, combinational |
| stat_vec | output | 32 | Pending coalesced-interrupt status bits |

## Verification
The hardest states to reach are the ones where two events land on the same edge. One is a completion together with a tick, which must start the timer already at one. The other is a status set together with a write-1-to-clear of that same bit. The bench drives these coincidences on purpose, cycle by cycle, from tasks that place the pulse, the tick and the bus write on one chosen edge. Between checks it sweeps the threshold, the timeout and all 32 index values. This shows that the counter and the timer restart after each firing and after each disable.

// File: rtl/coal_pkg.sv
package coal_pkg;
   localparam int REG_W = 32;
   localparam int ADDR_CTRL = 0;
   localparam int ADDR_STAT = 1;
endpackage

// File: rtl/coal_ctrl_reg.sv
module coal_ctrl_reg #(
   parameter int TMO_W = 16,
   parameter int CNT_W = 8,
   parameter int IDX_W = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_ctrl,
   input  logic [coal_pkg::REG_W-1:0] wdata,
   output logic                     en,
   output logic [TMO_W-1:0]         tmo,
   output logic [CNT_W-1:0]         thr,
   output logic [IDX_W-1:0]         idx,
   output logic [coal_pkg::REG_W-1:0] ctrl_word
);
   localparam int IDX_LSB = 3;
   localparam int CNT_LSB = IDX_LSB + IDX_W;
   localparam int TMO_LSB = CNT_LSB + CNT_W;

   if (TMO_LSB + TMO_W != coal_pkg::REG_W) begin : g_bad_layout
      $error("coal_ctrl_reg: field widths must fill the control word");
   end

   logic [1:0] unused_rsvd;
   assign unused_rsvd = wdata[2:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en  <= 1'b0;
         tmo <= TMO_W'(1);
         thr <= CNT_W'(1);
         idx <= IDX_W'(1);
      end else if (wr_ctrl) begin
         en  <= wdata[0];
         idx <= wdata[IDX_LSB +: IDX_W];
         if (!en) begin
            tmo <= wdata[TMO_LSB +: TMO_W];
            thr <= wdata[CNT_LSB +: CNT_W];
         end
      end
   end

   assign ctrl_word = {tmo, thr, idx, 2'b00, en};

   assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> ($stable(tmo) && $stable(thr)));
endmodule

// File: rtl/coal_engine.sv
module coal_engine #(
   parameter int TMO_W = 16,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [TMO_W-1:0] tmo,
   input  logic [CNT_W-1:0] thr,
   input  logic             cmpl,
   input  logic             tick,
   output logic             fire
);
   logic [CNT_W-1:0] cnt_q, cnt_inc;
   logic [TMO_W-1:0] tmr_q, tmr_inc;
   logic             pend, hit_cnt, hit_tmo;
   logic [CNT_W:0]   cnt_sum;
   logic [TMO_W:0]   tmr_sum;

   always_comb begin
      pend    = (cnt_q != '0) || cmpl;
      cnt_sum = {1'b0, cnt_q} + (CNT_W+1)'(cmpl);
      cnt_inc = cnt_sum[CNT_W] ? '1 : cnt_sum[CNT_W-1:0];
      tmr_sum = {1'b0, tmr_q} + (TMO_W+1)'(tick && pend);
      tmr_inc = tmr_sum[TMO_W] ? '1 : tmr_sum[TMO_W-1:0];
      hit_cnt = (thr != '0) && (cnt_inc >= thr);
      hit_tmo = (tmo != '0) && pend && (tmr_inc >= tmo);
      fire    = en && (hit_cnt || hit_tmo);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tmr_q <= '0;
      end else if (!en || fire) begin
         cnt_q <= '0;
         tmr_q <= '0;
      end else begin
         cnt_q <= cnt_inc;
         tmr_q <= tmr_inc;
      end
   end

   assert_cnt_below_thr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && thr != '0) |-> (cnt_q < thr));
   assert_tmr_below_tmo_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tmo != '0) |-> (tmr_q < tmo));
   assert_fire_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (cnt_q == '0 && tmr_q == '0));
   assert_idle_timer_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) |-> (tmr_q == '0));
endmodule

// File: rtl/coal_status.sv
module coal_status #(
   parameter int STAT_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [IDX_W-1:0]  idx,
   input  logic              wr_clr,
   input  logic [STAT_W-1:0] clr_mask,
   output logic [STAT_W-1:0] stat
);
   if (STAT_W > (1 << IDX_W) || STAT_W > coal_pkg::REG_W) begin : g_bad_width
      $error("coal_status: status width exceeds index range or word size");
   end

   logic [STAT_W-1:0] set_v;

   for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      assign set_v[i] = fire && (idx == IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    stat[i] <= 1'b0;
         else if (set_v[i])             stat[i] <= 1'b1;
         else if (wr_clr && clr_mask[i]) stat[i] <= 1'b0;
      end
   end

   assert_one_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_v));
   assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v != '0) |=> ((stat & $past(set_v)) == $past(set_v)));
endmodule

// File: rtl/cmpl_coalesce.sv
module cmpl_coalesce #(
   parameter int TMO_W  = 16,
   parameter int CNT_W  = 8,
   parameter int IDX_W  = 5,
   parameter int STAT_W = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmpl_pulse,
   input  logic        ms_tick,
   input  logic        bus_wr,
   input  logic        bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic [31:0] stat_vec
);
   localparam int PAD_W = coal_pkg::REG_W - STAT_W;

   logic             en, fire;
   logic [TMO_W-1:0] tmo;
   logic [CNT_W-1:0] thr;
   logic [IDX_W-1:0] idx;
   logic [31:0]      ctrl_word;
   logic [STAT_W-1:0] stat;
   logic             wr_ctrl, wr_stat;

   assign wr_ctrl = bus_wr && (bus_addr == 1'(coal_pkg::ADDR_CTRL));
   assign wr_stat = bus_wr && (bus_addr == 1'(coal_pkg::ADDR_STAT));

   coal_ctrl_reg #(.TMO_W(TMO_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(bus_wdata),
      .en(en), .tmo(tmo), .thr(thr), .idx(idx), .ctrl_word(ctrl_word));

   coal_engine #(.TMO_W(TMO_W), .CNT_W(CNT_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .en(en), .tmo(tmo), .thr(thr),
      .cmpl(cmpl_pulse), .tick(ms_tick), .fire(fire));

   coal_status #(.STAT_W(STAT_W), .IDX_W(IDX_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .fire(fire), .idx(idx),
      .wr_clr(wr_stat), .clr_mask(bus_wdata[STAT_W-1:0]), .stat(stat));

   if (PAD_W > 0) begin : g_pad
      assign stat_vec = {{PAD_W{1'b0}}, stat};
   end else begin : g_nopad
      assign stat_vec = stat;
   end

   assign bus_rdata = bus_addr ? stat_vec : ctrl_word;

   assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ((stat_vec & ~$past(stat_vec)) == '0));
   assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_word[2:1] == 2'b00);
endmodule

// File: tb/test_cmpl_coalesce.sv
module test_cmpl_coalesce;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmpl_pulse = 1'b0, ms_tick = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, stat_vec;
   int checks = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cmpl_coalesce i_cmpl_coalesce (.clk(clk), .rst_n(rst_n), .cmpl_pulse(cmpl_pulse),
      .ms_tick(ms_tick), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .stat_vec(stat_vec));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one clock: drives are applied 1 ns after a rising edge, outputs sampled 1 ns after the next
   task automatic cyc(input bit c, input bit t, input bit wr, input bit a, input logic [31:0] d);
      cmpl_pulse = c; ms_tick = t; bus_wr = wr; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      cmpl_pulse = 0; ms_tick = 0; bus_wr = 0; bus_wdata = '0;
   endtask

   function automatic logic [31:0] cw(input int tmo, input int thr, input int idx, input bit en);
      return {16'(tmo), 8'(thr), 5'(idx), 2'b00, en};
   endfunction

   task automatic cfg(input int tmo, input int thr, input int idx);
      cyc(0, 0, 1, 0, 32'h0);
      cyc(0, 0, 1, 0, cw(tmo, thr, idx, 1'b1));
      cyc(0, 0, 1, 1, 32'hFFFF_FFFF);
   endtask

   task automatic rd(input bit a, output logic [31:0] v);
      bus_addr = a; #0.5; v = bus_rdata;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      rd(0, v); chk(v == 32'h0001_0108, "R1 reset control", v, 32'h0001_0108);
      rd(1, v); chk(v == 0, "R1 reset status", v, 0);
      cyc(0, 0, 1, 0, 32'h0002_0306);
      rd(0, v); chk(v == 32'h0002_0300, "R1 reserved bits read 0", v, 32'h0002_0300);

      // R7: disabled, nothing sets
      cyc(0, 0, 1, 0, cw(1, 1, 2, 0));
      for (int k = 0; k < 5; k++) cyc(1, 1, 0, 0, 0);
      chk(stat_vec == 0, "R7 disabled no set", stat_vec, 0);

      // R2: lock while enabled
      cfg(7, 5, 2);
      cyc(0, 0, 1, 0, cw(9, 3, 2, 1));
      rd(0, v); chk(v == cw(7, 5, 2, 1), "R2 locked fields", v, cw(7, 5, 2, 1));

      // R3: threshold sweep, two rounds each
      for (int n = 1; n <= 8; n++) begin
         cfg(1000, n, 3);
         for (int r = 0; r < 2; r++) begin
            for (int k = 0; k < n - 1; k++) cyc(1, 0, 0, 0, 0);
            chk(stat_vec == 0, "R3 below threshold", stat_vec, 0);
            cyc(1, 0, 0, 0, 0);
            chk(stat_vec == 32'h8, "R3 threshold fire", stat_vec, 32'h8);
            cyc(0, 0, 1, 1, 32'h8);
            chk(stat_vec == 0, "R6 w1c clear", stat_vec, 0);
         end
      end

      // R6: index sweep and selective clear
      for (int i = 0; i < 32; i++) begin
         cfg(1000, 1, i);
         cyc(1, 0, 0, 0, 0);
         chk(stat_vec == (32'h1 << i), "R6 index bit", stat_vec, 32'h1 << i);
      end
      cfg(1000, 1, 0);
      cyc(1, 0, 0, 0, 0);
      cyc(0, 0, 1, 0, cw(1000, 1, 9, 1));
      cyc(1, 0, 0, 0, 0);
      cyc(0, 0, 1, 1, 32'h1);
      chk(stat_vec == 32'h200, "R6 selective clear", stat_vec, 32'h200);

      // R4 + R12: timer-only sweep, tick every third cycle
      for (int t = 1; t <= 6; t++) begin
         cfg(t, 0, 5);
         cyc(1, 0, 0, 0, 0);
         for (int k = 0; k < t - 1; k++) begin
            cyc(0, 1, 0, 0, 0); cyc(1, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
         end
         chk(stat_vec == 0, "R12 no count fire / R4 before timeout", stat_vec, 0);
         cyc(0, 1, 0, 0, 0);
         chk(stat_vec == 32'h20, "R4 timeout fire", stat_vec, 32'h20);
      end

      // R4 with threshold also active: timeout comes first
      cfg(3, 200, 6);
      cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0);
      chk(stat_vec == 0, "R4 two ticks", stat_vec, 0);
      cyc(0, 1, 0, 0, 0);
      chk(stat_vec == 32'h40, "R4 fire with threshold", stat_vec, 32'h40);

      // R9: ticks with no pending completion
      cfg(2, 0, 7);
      for (int k = 0; k < 20; k++) cyc(0, 1, 0, 0, 0);
      chk(stat_vec == 0, "R9 idle ticks", stat_vec, 0);
      cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0);
      chk(stat_vec == 0, "R9 timer started at completion", stat_vec, 0);
      cyc(0, 1, 0, 0, 0);
      chk(stat_vec == 32'h80, "R9 fire after completion", stat_vec, 32'h80);

      // R10: same-cycle completion and tick
      cfg(1, 0, 8);
      cyc(1, 1, 0, 0, 0);
      chk(stat_vec == 32'h100, "R10 coincident fire T=1", stat_vec, 32'h100);
      cfg(2, 0, 8);
      cyc(1, 1, 0, 0, 0);
      chk(stat_vec == 0, "R10 first tick counted", stat_vec, 0);
      cyc(0, 1, 0, 0, 0);
      chk(stat_vec == 32'h100, "R10 second tick fires", stat_vec, 32'h100);

      // R5: timeout zero never fires
      cfg(0, 0, 4);
      cyc(1, 0, 0, 0, 0);
      for (int k = 0; k < 50; k++) cyc(0, 1, 0, 0, 0);
      chk(stat_vec == 0, "R5 zero timeout", stat_vec, 0);

      // R8: disable clears count
      cfg(1000, 3, 10);
      cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0);
      cyc(0, 0, 1, 0, cw(1000, 3, 10, 0));
      cyc(0, 0, 1, 0, cw(1000, 3, 10, 1));
      cyc(1, 0, 0, 0, 0);
      chk(stat_vec == 0, "R8 count cleared by disable", stat_vec, 0);
      cyc(1, 0, 0, 0, 0);
      chk(stat_vec == 0, "R8 two after re-enable", stat_vec, 0);
      cyc(1, 0, 0, 0, 0);
      chk(stat_vec == 32'h400, "R8 third after re-enable", stat_vec, 32'h400);

      // R11: set and clear on same bit, same cycle
      cfg(1000, 1, 4);
      cyc(1, 0, 0, 0, 0);
      cyc(1, 0, 1, 1, 32'h10);
      chk(stat_vec == 32'h10, "R11 set wins", stat_vec, 32'h10);
      cyc(0, 0, 1, 1, 32'h10);
      chk(stat_vec == 0, "R11 later clear", stat_vec, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule